// File: doc/BRIEF.md
# PCI Interrupt Request Router

This block collects the four active-low PCI interrupt request lines and gives the processor one interrupt output. Each line has two configuration settings. The first is its detection type: the line either follows its level or latches a falling edge. The second is a 3-bit priority level that software assigns. A line that is pending and not masked raises the processor interrupt output. The processor then issues an acknowledge. The block chooses the most urgent unmasked pending line and, one clock later, returns an 8-bit vector. The vector is a programmable base plus that line's level.

Software sets up the block through a small write-only register port with a 3-bit address and 8-bit data. The register layout is: address 0 selects the detection type of each line (bit i for line i, 1 means edge). Address 1 masks lines (bit i for line i, 1 means masked). Address 2 holds the vector base. Addresses 4 to 7 hold the level of lines A to D, in data bits [2:0]. Each request line passes through a two-stage synchronizer before detection.

Top module: `pci_irq_router`

## Requirements
- R1: The request inputs are active low. An unmasked line in level mode that is held low raises intrOut at the second rising edge after the input falls.
- R2: In level mode a line is pending only while its synchronized input is low. Releasing it drops intrOut two edges later, with no acknowledge needed.
- R3: In edge mode a high-to-low transition of the synchronized input sets a pending latch, at the third edge after the input falls. The latch holds after the input returns high.
- R4: A masked line never raises intrOut and never wins an acknowledge.
- R5: intrOut is high exactly when at least one unmasked line is pending.
- R6: On the edge that samples ackStrobe high, the block registers the vector. vectorValid is high for exactly the following cycle, and vectorOut = (base + winner level) mod 256.
- R7: Among unmasked pending lines the lowest level number wins. When levels are equal, the line earlier in the order A, B, C, D wins.
- R8: An acknowledge with no unmasked pending line returns base + 7 and changes no pending state.
- R9: After reset all lines are masked and in level mode, the base is 0x00, and line i has level i. A write to address 3 has no effect.
- R10: An acknowledge clears the edge latch of the winning line only. A winning level-mode line stays pending while its input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqInN | input | 4 | PCI interrupt request lines A..D (bit 0 = A), active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgWrData | input | 8 | Register write data |
| ackStrobe | input | 1 | Interrupt acknowledge request, one cycle per acknowledge |
| intrOut | output | 1 | Interrupt request to the processor |
| vectorOut | output | 8 | Vector returned for the last acknowledge |
| vectorValid | output | 1 | vectorOut is valid this cycle |

## Verification
The response times differ by request type. A level request reaches intrOut two edges after the input changes, and an edge request three edges after the fall. An acknowledge gives a vector in the cycle after the edge that samples it, and it clears an edge latch at that same edge. The bench keeps a behavioural model that is stepped on every rising edge and includes the same synchronizer delay. It compares intrOut, vectorValid and vectorOut at every falling edge. Directed checks wait the exact number of falling edges for each of these delays and then check the result.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int LINE_CNT = 4;
  localparam int SEL_W = $clog2(LINE_CNT);

  // Control strobes handed from the decoder to the datapath
  typedef struct packed {
    logic             wrMode;
    logic             wrMask;
    logic             wrBase;
    logic             wrLevel;
    logic [SEL_W-1:0] levelSel;
    logic             ack;
  } ctrlStrobes_t;
endpackage

// File: rtl/pir_ctrl.sv
module pir_ctrl
  import pci_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              ackStrobe,
  output ctrlStrobes_t      strobes
);
  // Address layout: 0 mode, 1 mask, 2 base, 3 unused, 4..7 per-line level
  always_comb begin
    strobes          = '0;
    strobes.ack      = ackStrobe;
    strobes.levelSel = cfgAddr[SEL_W-1:0];
    if (cfgWrEn) begin
      if (cfgAddr[ADDR_W-1]) begin
        strobes.wrLevel = 1'b1;
      end else begin
        case (cfgAddr[1:0])
          2'd0:    strobes.wrMode = 1'b1;
          2'd1:    strobes.wrMask = 1'b1;
          2'd2:    strobes.wrBase = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pir_arbiter.sv
module pir_arbiter #(
  parameter int NUM_LINES = 4,
  parameter int LEVEL_W   = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_LINES-1:0]              req,
  input  logic [NUM_LINES-1:0][LEVEL_W-1:0] levels,
  output logic [NUM_LINES-1:0]              grant,
  output logic                              anyReq,
  output logic [LEVEL_W-1:0]                winLevel
);
  // Lowest level wins; strict compare keeps the lower index on ties
  always_comb begin
    grant    = '0;
    anyReq   = 1'b0;
    winLevel = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i] && (!anyReq || levels[i] < winLevel)) begin
        grant    = '0;
        grant[i] = 1'b1;
        winLevel = levels[i];
        anyReq   = 1'b1;
      end
    end
  end

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  p_grant_when_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|grant));
endmodule

// File: rtl/pir_datapath.sv
module pir_datapath
  import pci_irq_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int LEVEL_W     = 3,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqInN,
  input  logic [VEC_W-1:0]     cfgWrData,
  input  ctrlStrobes_t         strobes,
  output logic                 intrOut,
  output logic [VEC_W-1:0]     vectorOut,
  output logic                 vectorValid
);
  localparam logic [VEC_W-1:0] SPUR_OFS = VEC_W'((1 << LEVEL_W) - 1);

  logic [NUM_LINES-1:0]              modeReg;   // 1 = edge
  logic [NUM_LINES-1:0]              maskReg;   // 1 = masked
  logic [VEC_W-1:0]                  baseReg;
  logic [NUM_LINES-1:0][LEVEL_W-1:0] levelReg;
  logic [NUM_LINES-1:0]              syncLow;
  logic [NUM_LINES-1:0]              prevLow;
  logic [NUM_LINES-1:0]              edgeLatch;
  logic [NUM_LINES-1:0]              pending;
  logic [NUM_LINES-1:0]              eligible;
  logic [NUM_LINES-1:0]              grant;
  logic                              anyReq;
  logic [LEVEL_W-1:0]                winLevel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeReg <= '0;
      maskReg <= '1;
      baseReg <= '0;
    end else begin
      if (strobes.wrMode) modeReg <= cfgWrData[NUM_LINES-1:0];
      if (strobes.wrMask) maskReg <= cfgWrData[NUM_LINES-1:0];
      if (strobes.wrBase) baseReg <= cfgWrData;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   fallSeen;
    logic                   clrHit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        levelReg[g] <= LEVEL_W'(g);
      end else if (strobes.wrLevel && strobes.levelSel == g) begin
        levelReg[g] <= cfgWrData[LEVEL_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        syncQ      <= '1;
        prevLow[g] <= 1'b0;
      end else begin
        syncQ      <= {syncQ[SYNC_STAGES-2:0], irqInN[g]};
        prevLow[g] <= syncLow[g];
      end
    end
    assign syncLow[g] = ~syncQ[SYNC_STAGES-1];
    assign fallSeen   = syncLow[g] && !prevLow[g];
    assign clrHit     = strobes.ack && grant[g];

    always_ff @(posedge clk) begin
      if (!rst_n)          edgeLatch[g] <= 1'b0;
      else if (!modeReg[g]) edgeLatch[g] <= 1'b0;
      else                 edgeLatch[g] <= (edgeLatch[g] && !clrHit) || fallSeen;
    end

    assign pending[g] = modeReg[g] ? edgeLatch[g] : syncLow[g];

    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edgeLatch[g] && modeReg[g] && !strobes.ack && !strobes.wrMode) |=> edgeLatch[g]);
  end

  assign eligible = pending & ~maskReg;
  assign intrOut  = |eligible;

  pir_arbiter #(.NUM_LINES(NUM_LINES), .LEVEL_W(LEVEL_W)) uArb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (eligible),
    .levels  (levelReg),
    .grant   (grant),
    .anyReq  (anyReq),
    .winLevel(winLevel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vectorValid <= 1'b0;
      vectorOut   <= '0;
    end else begin
      vectorValid <= strobes.ack;
      if (strobes.ack)
        vectorOut <= baseReg + (anyReq ? {{(VEC_W-LEVEL_W){1'b0}}, winLevel} : SPUR_OFS);
    end
  end

  p_ack_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ack |=> vectorValid);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.ack |=> !vectorValid);
  p_mask_no_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & maskReg) == '0);
  p_intr_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    intrOut |-> (|pending));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_pkg::*;
#(
  parameter int NUM_LINES   = LINE_CNT,
  parameter int LEVEL_W     = 3,
  parameter int VEC_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqInN,
  input  logic                 cfgWrEn,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [VEC_W-1:0]     cfgWrData,
  input  logic                 ackStrobe,
  output logic                 intrOut,
  output logic [VEC_W-1:0]     vectorOut,
  output logic                 vectorValid
);
  ctrlStrobes_t strobes;

  pir_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .ackStrobe(ackStrobe),
    .strobes  (strobes)
  );

  pir_datapath #(
    .NUM_LINES(NUM_LINES), .LEVEL_W(LEVEL_W), .VEC_W(VEC_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .irqInN     (irqInN),
    .cfgWrData  (cfgWrData),
    .strobes    (strobes),
    .intrOut    (intrOut),
    .vectorOut  (vectorOut),
    .vectorValid(vectorValid)
  );
endmodule

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irqInN = 4'hF;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       ackStrobe = 1'b0;
  logic       intrOut;
  logic [7:0] vectorOut;
  logic       vectorValid;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pci_irq_router uut (
    .clk(clk), .rst_n(rst_n), .irqInN(irqInN), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .ackStrobe(ackStrobe),
    .intrOut(intrOut), .vectorOut(vectorOut), .vectorValid(vectorValid)
  );

  // Behavioural reference model
  bit   mS1 [4];
  bit   mS2 [4];
  bit   mPrevHigh [4];
  bit   mLatch [4];
  bit   mEdge [4];
  bit   mMask [4];
  int   mLvl [4];
  int   mBase;
  bit   expVld;
  int   expVec;

  function automatic bit mPend(int i);
    return mEdge[i] ? mLatch[i] : !mS2[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        mS1[i] = 1; mS2[i] = 1; mPrevHigh[i] = 1; mLatch[i] = 0;
        mEdge[i] = 0; mMask[i] = 1; mLvl[i] = i;
      end
      mBase = 0; expVld = 0; expVec = 0;
    end else begin
      int win;
      bit clr [4];
      win = -1;
      for (int i = 0; i < 4; i++) begin
        clr[i] = 0;
        if (mPend(i) && !mMask[i] && (win < 0 || mLvl[i] < mLvl[win])) win = i;
      end
      expVld = ackStrobe;
      if (ackStrobe) begin
        expVec = (win < 0) ? (mBase + 7) % 256 : (mBase + mLvl[win]) % 256;
        if (win >= 0) clr[win] = 1;
      end
      for (int i = 0; i < 4; i++) begin
        bit fall;
        fall = mPrevHigh[i] && !mS2[i];
        mLatch[i] = mEdge[i] ? ((mLatch[i] && !clr[i]) || fall) : 0;
        mPrevHigh[i] = mS2[i];
        mS2[i] = mS1[i];
        mS1[i] = irqInN[i];
      end
      if (cfgWrEn) begin
        case (cfgAddr)
          3'd0: for (int i = 0; i < 4; i++) mEdge[i] = cfgWrData[i];
          3'd1: for (int i = 0; i < 4; i++) mMask[i] = cfgWrData[i];
          3'd2: mBase = cfgWrData;
          3'd4, 3'd5, 3'd6, 3'd7: mLvl[cfgAddr - 4] = cfgWrData[2:0];
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model (R5, R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit expIntr;
      expIntr = 0;
      for (int i = 0; i < 4; i++) if (mPend(i) && !mMask[i]) expIntr = 1;
      tests++;
      if (intrOut !== expIntr) begin
        fails++;
        $display("FAIL R5 model intrOut act=%0b exp=%0b t=%0t", intrOut, expIntr, $time);
      end
      tests++;
      if (vectorValid !== expVld || (expVld && vectorOut !== 8'(expVec))) begin
        fails++;
        $display("FAIL R6 model vector act=%0b/%0h exp=%0b/%0h t=%0t",
                 vectorValid, vectorOut, expVld, expVec, $time);
      end
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wrCfg(logic [2:0] a, logic [7:0] d);
    cfgWrEn = 1; cfgAddr = a; cfgWrData = d;
    step();
    cfgWrEn = 0;
  endtask

  task automatic doAck(string tag, int expV);
    ackStrobe = 1;
    step();
    ackStrobe = 0;
    chk(vectorValid === 1'b1 && vectorOut === 8'(expV), tag, vectorOut, expV);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R9 reset state: all masked so no interrupt
    chk(intrOut === 1'b0 && vectorValid === 1'b0, "R9 reset outputs", intrOut, 0);
    // R8 spurious acknowledge at reset: base 0 + 7
    doAck("R8 spurious vector at reset", 8'h07);
    step();
    chk(vectorValid === 1'b0, "R6 valid one cycle", vectorValid, 0);

    wrCfg(3'd1, 8'h00);
    wrCfg(3'd2, 8'h40);
    // R1 level line B held low
    irqInN = 4'b1101;
    step();
    chk(intrOut === 1'b0, "R1 not yet after one edge", intrOut, 0);
    step();
    chk(intrOut === 1'b1, "R1 level request raises intr", intrOut, 1);
    doAck("R6 vector base+level B", 8'h41);
    chk(intrOut === 1'b1, "R10 level line stays pending after ack", intrOut, 1);
    irqInN = 4'hF;
    step(2);
    chk(intrOut === 1'b0, "R2 release drops intr", intrOut, 0);

    // R4 masked line C
    wrCfg(3'd1, 8'h04);
    irqInN = 4'b1011;
    step(3);
    chk(intrOut === 1'b0, "R4 masked line no intr", intrOut, 0);
    doAck("R4 masked line cannot win", 8'h47);
    irqInN = 4'hF;
    step(2);

    // R7 priority: A=5, B=2, C=2, D=6
    wrCfg(3'd4, 8'h05);
    wrCfg(3'd5, 8'h02);
    wrCfg(3'd6, 8'h02);
    wrCfg(3'd7, 8'h06);
    wrCfg(3'd1, 8'h00);
    irqInN = 4'h0;
    step(2);
    doAck("R7 tie goes to B before C", 8'h42);
    wrCfg(3'd6, 8'h01);
    doAck("R7 lower level C wins", 8'h41);
    irqInN = 4'hF;
    step(3);

    // R3 edge mode on A
    wrCfg(3'd0, 8'h01);
    irqInN = 4'b1110;
    step(2);
    chk(intrOut === 1'b0, "R3 edge latch not yet set", intrOut, 0);
    step();
    chk(intrOut === 1'b1, "R3 edge latch set", intrOut, 1);
    irqInN = 4'hF;
    step(4);
    chk(intrOut === 1'b1, "R3 latch holds after release", intrOut, 1);
    doAck("R6 edge line vector", 8'h45);
    chk(intrOut === 1'b0, "R10 ack clears edge latch", intrOut, 0);
    // R8: spurious ack leaves state unchanged
    doAck("R8 spurious vector", 8'h47);
    chk(intrOut === 1'b0, "R8 no state change", intrOut, 0);

    // R9 write to address 3 ignored
    wrCfg(3'd3, 8'hFF);
    doAck("R9 address 3 write ignored", 8'h47);

    // R6 base wrap with level 5 on A (edge)
    wrCfg(3'd2, 8'hFE);
    irqInN = 4'b1110;
    step(2);
    irqInN = 4'hF;
    step(3);
    doAck("R6 vector wraps", 8'h03);
    step(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 5000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule